// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame should be kept or dropped. It looks only at the six-byte destination address, the frame length and a few configuration inputs. The address arrives one byte per clock after a frame-start strobe. A 64-bit multicast hash table is loaded beforehand from a list of multicast addresses. Each address in the list is hashed with CRC-32, and its hash picks one bit of the table.

A single CRC engine serves both jobs, because table loading and frame filtering never overlap. The controller is a four-state machine:

- `ST_IDLE` waits for work. `ld_start` (which has priority) takes the transition *idle→load*, or *idle→idle* when the list holds no whole entry. `frm_start` takes the transition *idle→addr*.
- `ST_LOAD` takes list bytes. After the last byte of the last entry it takes the transition *load→idle*.
- `ST_ADDR` collects the destination address. After the sixth byte it takes the transition *addr→decide*.
- `ST_DECIDE` presents the decision for one cycle. It always takes the transition *decide→idle*.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset, `busy`, `dec_valid`, `accept` and `bcmc` are 0 and every hash table bit is 0. With multicast enabled, a multicast frame is therefore rejected.
- R2: The hash of an address is taken as follows. A 32-bit register is preset to all ones. The six bytes are folded in first-byte-first, each byte least significant bit first. For each data bit, the feedback is register bit 31 XOR the data bit. The register then shifts left by one, and it is XORed with 0x04C11DB7 when the feedback is 1. There is no final inversion. The table index is register bits 7:2.
- R3: `ld_start` in `ST_IDLE` clears the whole table. Each complete six-byte list entry then sets the table bit at its hash. `busy` is 1 from the cycle after `ld_start` until the last list byte has been taken.
- R4: The number of list entries is `ld_len` (in bytes) divided by 6, rounded down, and clamped to 64. When that count is reached, `busy` drops and further bytes are not taken.
- R5: When `cfg_promisc` is 1 and the frame passes the R9 gates, the frame is accepted with `bcmc` = 0, whatever its address.
- R6: When the address is all ones (broadcast), the frame is rejected if `cfg_bcast_block` is 1. Otherwise it is accepted with `bcmc` = 1.
- R7: When bit 0 of the first address byte is 1 and the address is not broadcast, the frame is accepted with `bcmc` = 1 only if `cfg_mcast_en` is 1 and the table bit at the address hash is 1. Otherwise it is rejected.
- R8: Any other address is accepted, with `bcmc` = 0, only if all six bytes equal `station_addr`. Byte 0, the first on the wire, is `station_addr[7:0]`.
- R9: A frame is rejected, even in promiscuous mode, in any of these cases at `frm_start`: `frm_len` is less than `min_len`, `link_up` is 0, or `rx_active` is 0. A frame whose length equals `min_len` passes this gate.
- R10: `dec_valid` is 1 for exactly one cycle: the cycle after the clock edge that takes the sixth address byte. `accept` and `bcmc` are 0 whenever `dec_valid` is 0.
- R11: While `busy` is 1, `frm_start` and `addr_valid` are ignored and no decision is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_promisc | input | 1 | Accept every frame that passes the gates |
| cfg_bcast_block | input | 1 | Reject broadcast frames |
| cfg_mcast_en | input | 1 | Allow hash-matched multicast frames |
| station_addr | input | 48 | Own unicast address, byte 0 in bits 7:0 |
| link_up | input | 1 | Link is up |
| rx_active | input | 1 | Receiver is running (not suspended) |
| min_len | input | 14 | Minimum frame length in bytes |
| frm_start | input | 1 | Frame start strobe, qualifies `frm_len` |
| frm_len | input | 14 | Length of the frame in bytes |
| addr_valid | input | 1 | `addr_byte` holds a destination address byte |
| addr_byte | input | 8 | Destination address byte, first byte first |
| ld_start | input | 1 | Start loading a multicast list |
| ld_len | input | 16 | Length of the list in bytes |
| ld_valid | input | 1 | `ld_byte` holds a list byte |
| ld_byte | input | 8 | List byte, entries back to back |
| busy | output | 1 | Table load in progress |
| dec_valid | output | 1 | Decision is valid this cycle |
| accept | output | 1 | Frame accepted |
| bcmc | output | 1 | Accepted frame is broadcast or multicast |

## Verification
The assertions assume that the configuration inputs and `station_addr` stay steady from `frm_start` until the decision cycle. They also assume that `ld_start` and `frm_start` are offered only while the block is idle, except in the deliberate overlap scenario. The bench changes configuration only between frames and always waits for the decision before it starts anything new. Its one overlap scenario drives frame strobes and address bytes during a load, so that the test shows those inputs are ignored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ADDR,
        ST_DECIDE
    } rxf_state_e;

    localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    // Fold one byte into the CRC register, least significant data bit first.
    function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxf_crc.sv
module rxf_crc #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preset,
    input  logic             step,
    input  logic [7:0]       din,
    output logic [IDX_W-1:0] hash_q,
    output logic [IDX_W-1:0] hash_nxt
);
    import rxf_pkg::*;

    logic [31:0] crc_q;
    logic [31:0] crc_nxt;

    assign crc_nxt  = crc_fold(crc_q, din);
    assign hash_q   = crc_q[IDX_W+1:2];
    assign hash_nxt = crc_nxt[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_PRESET;
        else if (preset) crc_q <= CRC_PRESET;
        else if (step)   crc_q <= crc_nxt;
    end

    // R2: a preset always leaves the register at all ones
    a_r2_preset_ones: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (crc_q == CRC_PRESET));

    // R2: without preset or step the register holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset && !step) |=> $stable(crc_q));

endmodule

// File: rtl/rxf_hash_tbl.sv
module rxf_hash_tbl #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] look_idx,
    output logic             hit
);
    localparam int TBL_SIZE = 1 << IDX_W;

    logic [TBL_SIZE-1:0] bits_q;
    logic [TBL_SIZE-1:0] bits_nxt;

    for (genvar g = 0; g < TBL_SIZE; g++) begin : g_bit
        assign bits_nxt[g] = clear ? 1'b0
                           : (bits_q[g] | (set_en && (set_idx == IDX_W'(g))));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_nxt;
    end

    assign hit = bits_q[look_idx];

    // R3: a clear leaves every bit at 0
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (bits_q == '0));

    // R3: one set adds at most one bit
    a_r3_single_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear) |=> ($countones(bits_q) <= $countones($past(bits_q)) + 1));

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter #(
    parameter int ADDR_BYTES  = 6,
    parameter int IDX_W       = 6,
    parameter int LEN_W       = 14,
    parameter int LIST_W      = 16,
    parameter int MAX_ENTRIES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_promisc,
    input  logic                    cfg_bcast_block,
    input  logic                    cfg_mcast_en,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    link_up,
    input  logic                    rx_active,
    input  logic [LEN_W-1:0]        min_len,
    input  logic                    frm_start,
    input  logic [LEN_W-1:0]        frm_len,
    input  logic                    addr_valid,
    input  logic [7:0]              addr_byte,
    input  logic                    ld_start,
    input  logic [LIST_W-1:0]       ld_len,
    input  logic                    ld_valid,
    input  logic [7:0]              ld_byte,
    output logic                    busy,
    output logic                    dec_valid,
    output logic                    accept,
    output logic                    bcmc
);
    import rxf_pkg::*;

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int BC_W   = $clog2(ADDR_BYTES);
    localparam int ENT_W  = $clog2(MAX_ENTRIES + 1);
    localparam logic [BC_W-1:0]  LAST_BYTE = BC_W'(ADDR_BYTES - 1);
    localparam logic [ENT_W-1:0] ENT_MAX   = ENT_W'(MAX_ENTRIES);

    rxf_state_e        state_q;
    logic [BC_W-1:0]   byte_cnt_q;
    logic [ENT_W-1:0]  ent_cnt_q;
    logic [ENT_W-1:0]  ent_tgt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              gate_bad_q;

    logic [LIST_W-1:0] ent_req;
    logic [ENT_W-1:0]  ent_tgt;
    logic              last_byte;
    logic              crc_preset, crc_step;
    logic [7:0]        crc_din;
    logic [IDX_W-1:0]  hash_q, hash_nxt;
    logic              tbl_clear, tbl_set, tbl_hit;

    assign ent_req   = ld_len / LIST_W'(ADDR_BYTES);
    assign ent_tgt   = (ent_req > LIST_W'(MAX_ENTRIES)) ? ENT_MAX : ent_req[ENT_W-1:0];
    assign last_byte = (byte_cnt_q == LAST_BYTE);

    // Shared datapath controls
    always_comb begin
        crc_preset = 1'b0;
        crc_step   = 1'b0;
        crc_din    = addr_byte;
        tbl_clear  = 1'b0;
        tbl_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                crc_preset = ld_start || frm_start;
                tbl_clear  = ld_start;
            end
            ST_LOAD: begin
                crc_din    = ld_byte;
                crc_step   = ld_valid;
                tbl_set    = ld_valid && last_byte;
                crc_preset = ld_valid && last_byte;
            end
            ST_ADDR:   crc_step = addr_valid;
            ST_DECIDE: ;
        endcase
    end

    rxf_crc #(.IDX_W(IDX_W)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset   (crc_preset),
        .step     (crc_step),
        .din      (crc_din),
        .hash_q   (hash_q),
        .hash_nxt (hash_nxt)
    );

    rxf_hash_tbl #(.IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tbl_clear),
        .set_en   (tbl_set),
        .set_idx  (hash_nxt),
        .look_idx (hash_q),
        .hit      (tbl_hit)
    );

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            byte_cnt_q <= '0;
            ent_cnt_q  <= '0;
            ent_tgt_q  <= '0;
            addr_q     <= '0;
            gate_bad_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    byte_cnt_q <= '0;
                    if (ld_start) begin
                        ent_cnt_q <= '0;
                        ent_tgt_q <= ent_tgt;
                        state_q   <= (ent_tgt == '0) ? ST_IDLE : ST_LOAD;
                    end else if (frm_start) begin
                        gate_bad_q <= (frm_len < min_len) || !link_up || !rx_active;
                        state_q    <= ST_ADDR;
                    end
                end
                ST_LOAD: begin
                    if (ld_valid) begin
                        if (last_byte) begin
                            byte_cnt_q <= '0;
                            ent_cnt_q  <= ent_cnt_q + 1'b1;
                            if (ent_cnt_q + 1'b1 == ent_tgt_q) state_q <= ST_IDLE;
                        end else begin
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (addr_valid) begin
                        addr_q[byte_cnt_q*8 +: 8] <= addr_byte;
                        if (last_byte) state_q <= ST_DECIDE;
                        else           byte_cnt_q <= byte_cnt_q + 1'b1;
                    end
                end
                ST_DECIDE: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q == ST_LOAD);
        dec_valid = (state_q == ST_DECIDE);
        accept    = 1'b0;
        bcmc      = 1'b0;
        if (state_q == ST_DECIDE) begin
            if (gate_bad_q) begin
                accept = 1'b0;
            end else if (cfg_promisc) begin
                accept = 1'b1;
            end else if (&addr_q) begin
                accept = !cfg_bcast_block;
                bcmc   = !cfg_bcast_block;
            end else if (addr_q[0]) begin
                accept = cfg_mcast_en && tbl_hit;
                bcmc   = cfg_mcast_en && tbl_hit;
            end else begin
                accept = (addr_q == station_addr);
            end
        end
    end

    // R10: a decision lasts exactly one cycle
    a_r10_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    // R10: a decision follows an accepted address byte
    a_r10_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(addr_valid));

    // R10: no verdict outside the decision cycle
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!accept && !bcmc));

    // R3: a load only begins on a load request
    a_r3_load_begins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ld_start));

    // R4: the entry counter never passes the cap
    a_r4_entry_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ent_cnt_q <= ENT_MAX);

    // R11: a load cannot end in a decision
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dec_valid);

endmodule

// File: tb/rxf_addr_filter_tb.sv
module rxf_addr_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h5544_3322_1102;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC_A    = 48'h0100_005E_0001;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_promisc, cfg_bcast_block, cfg_mcast_en;
    logic [47:0] station_addr;
    logic        link_up, rx_active;
    logic [13:0] min_len, frm_len;
    logic        frm_start, addr_valid, ld_start, ld_valid;
    logic [7:0]  addr_byte, ld_byte;
    logic [15:0] ld_len;
    logic        busy, dec_valid, accept, bcmc;

    int n_run  = 0;
    int n_fail = 0;
    logic [47:0] mc_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxf_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_promisc(cfg_promisc), .cfg_bcast_block(cfg_bcast_block),
        .cfg_mcast_en(cfg_mcast_en), .station_addr(station_addr),
        .link_up(link_up), .rx_active(rx_active), .min_len(min_len),
        .frm_start(frm_start), .frm_len(frm_len),
        .addr_valid(addr_valid), .addr_byte(addr_byte),
        .ld_start(ld_start), .ld_len(ld_len),
        .ld_valid(ld_valid), .ld_byte(ld_byte),
        .busy(busy), .dec_valid(dec_valid), .accept(accept), .bcmc(bcmc)
    );

    // Hash index as stated in R2
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[31] ^ a[8*b+k];
                c  = c << 1;
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return c[7:2];
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [47:0] a, input logic [13:0] len,
                              input logic exp_acc, input logic exp_flag, input string req);
        frm_start = 1'b1; frm_len = len;
        tick;
        frm_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            addr_valid = 1'b1; addr_byte = a[8*i +: 8];
            tick;
        end
        addr_valid = 1'b0;
        check(dec_valid == 1'b1, "R10 decision valid", 32'(dec_valid), 1);
        check(accept == exp_acc, req, 32'(accept), 32'(exp_acc));
        check(bcmc == exp_flag, req, 32'(bcmc), 32'(exp_flag));
        tick;
        check(dec_valid == 1'b0 && accept == 1'b0, "R10 single cycle", 32'(dec_valid), 0);
    endtask

    // Load n copies of one address; the list length is given separately
    task automatic load_same(input logic [15:0] len, input int n, input logic [47:0] a, input string req);
        ld_start = 1'b1; ld_len = len;
        tick;
        ld_start = 1'b0;
        if (n > 0) check(busy == 1'b1, req, 32'(busy), 1);
        for (int e = 0; e < n; e++) begin
            for (int i = 0; i < 6; i++) begin
                if (e == n-1 && i == 5)
                    check(busy == 1'b1, req, 32'(busy), 1);
                ld_valid = 1'b1; ld_byte = a[8*i +: 8];
                tick;
            end
        end
        ld_valid = 1'b0;
        check(busy == 1'b0, req, 32'(busy), 0);
    endtask

    task automatic t_reset;
        check(busy == 0 && dec_valid == 0 && accept == 0 && bcmc == 0, "R1 reset outputs",
              {28'd0, busy, dec_valid, accept, bcmc}, 0);
        cfg_mcast_en = 1'b1;
        send_frame(MC_A, 14'd64, 1'b0, 1'b0, "R1 table empty after reset");
    endtask

    task automatic t_unicast;
        send_frame(STATION, 14'd64, 1'b1, 1'b0, "R8 station match");
        send_frame(STATION ^ 48'h0100_0000_0000, 14'd64, 1'b0, 1'b0, "R8 last byte differs");
        send_frame(48'h5544_3322_1104, 14'd64, 1'b0, 1'b0, "R8 first byte differs");
    endtask

    task automatic t_bcast;
        cfg_bcast_block = 1'b0;
        send_frame(BCAST, 14'd64, 1'b1, 1'b1, "R6 broadcast accepted");
        cfg_bcast_block = 1'b1;
        send_frame(BCAST, 14'd64, 1'b0, 1'b0, "R6 broadcast blocked");
        cfg_bcast_block = 1'b0;
    endtask

    task automatic t_multicast;
        load_same(16'd6, 1, MC_A, "R3 busy during load");
        cfg_mcast_en = 1'b1;
        send_frame(MC_A, 14'd64, 1'b1, 1'b1, "R7 R2 hashed multicast hit");
        send_frame(mc_b, 14'd64, 1'b0, 1'b0, "R7 R2 multicast miss");
        cfg_mcast_en = 1'b0;
        send_frame(MC_A, 14'd64, 1'b0, 1'b0, "R7 multicast disabled");
        cfg_mcast_en = 1'b1;
        load_same(16'd6, 1, mc_b, "R3 reload");
        send_frame(MC_A, 14'd64, 1'b0, 1'b0, "R3 reload clears old bit");
        send_frame(mc_b, 14'd64, 1'b1, 1'b1, "R3 reload sets new bit");
    endtask

    task automatic t_counts;
        load_same(16'd13, 2, MC_A, "R4 thirteen bytes give two entries");
        send_frame(MC_A, 14'd64, 1'b1, 1'b1, "R4 entries loaded");
        load_same(16'd5, 0, MC_A, "R4 five bytes give no entry");
        send_frame(MC_A, 14'd64, 1'b0, 1'b0, "R4 empty list clears table");
        load_same(16'd400, 64, mc_b, "R4 clamp to 64 entries");
        send_frame(mc_b, 14'd64, 1'b1, 1'b1, "R4 clamped list loaded");
    endtask

    task automatic t_promisc;
        cfg_promisc = 1'b1; cfg_bcast_block = 1'b1; cfg_mcast_en = 1'b0;
        send_frame(48'h0A0B_0C0D_0E10, 14'd64, 1'b1, 1'b0, "R5 promiscuous unicast");
        send_frame(BCAST, 14'd64, 1'b1, 1'b0, "R5 promiscuous over broadcast block");
        send_frame(MC_A, 14'd64, 1'b1, 1'b0, "R5 promiscuous multicast");
        cfg_bcast_block = 1'b0; cfg_mcast_en = 1'b1;
    endtask

    task automatic t_gates;
        cfg_promisc = 1'b1;
        send_frame(STATION, 14'd59, 1'b0, 1'b0, "R9 short frame");
        send_frame(STATION, 14'd60, 1'b1, 1'b0, "R9 length equals minimum");
        link_up = 1'b0;
        send_frame(STATION, 14'd64, 1'b0, 1'b0, "R9 link down");
        link_up = 1'b1; rx_active = 1'b0;
        send_frame(STATION, 14'd64, 1'b0, 1'b0, "R9 receiver suspended");
        rx_active = 1'b1; cfg_promisc = 1'b0;
        send_frame(BCAST, 14'd10, 1'b0, 1'b0, "R9 short broadcast");
    endtask

    task automatic t_overlap;
        logic seen;
        seen = 1'b0;
        ld_start = 1'b1; ld_len = 16'd6;
        tick;
        ld_start = 1'b0;
        frm_start = 1'b1; frm_len = 14'd64;
        tick;
        frm_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ld_valid = 1'b1; ld_byte = MC_A[8*i +: 8];
            addr_valid = 1'b1; addr_byte = STATION[8*i +: 8];
            seen = seen | dec_valid;
            tick;
        end
        ld_valid = 1'b0; addr_valid = 1'b0;
        seen = seen | dec_valid;
        tick;
        seen = seen | dec_valid;
        check(!seen, "R11 no decision during load", 32'(seen), 0);
        check(busy == 1'b0, "R11 load completed", 32'(busy), 0);
        send_frame(MC_A, 14'd64, 1'b1, 1'b1, "R11 list bytes taken as list");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        cfg_promisc = 1'b0; cfg_bcast_block = 1'b0; cfg_mcast_en = 1'b0;
        station_addr = STATION; link_up = 1'b1; rx_active = 1'b1;
        min_len = 14'd60; frm_start = 1'b0; frm_len = '0;
        addr_valid = 1'b0; addr_byte = '0;
        ld_start = 1'b0; ld_len = '0; ld_valid = 1'b0; ld_byte = '0;
        mc_b = MC_A;
        for (int k = 0; k < 256; k++) begin
            mc_b[47:40] = 8'(k);
            if (ref_idx(mc_b) != ref_idx(MC_A)) break;
        end
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        t_reset;
        t_unicast;
        t_bcast;
        t_multicast;
        t_counts;
        t_promisc;
        t_gates;
        t_overlap;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule